// File: doc/BRIEF.md
# Raster Interrupt Status Controller

This block is the interrupt unit beside a video raster timing generator. It collects three raster events (vertical blank, an animation-line strobe and a cursor-line event that it generates itself), records each in a sticky status bit and drives one registered interrupt line to the system. A mask register selects which recorded events may reach that line. Masking does not stop an event from being recorded.

The cursor-line event is produced inside the block. It counts line-end strobes from the timing generator and fires once every N lines, where N is a programmable line count. The period is therefore the horizontal total times N pixel clocks. Software reads the status and the line count back through a small register port. It acknowledges each source by reading its own clear location, and every such read returns zero.

Top module: `rirq_ctrl`

## Requirements
- R1: Status and mask bit encoding is bit 0 vertical blank, bit 1 animation, bit 2 cursor line. The register addresses are 0 mask (read/write, low 3 bits), 1 status (read only), 2 cursor line count (read/write, LINE_W bits), 3 cursor acknowledge, 4 animation acknowledge, 5 vertical-blank acknowledge. Unmapped addresses read zero.
- R2: A source event sets its status bit on the next clock edge whether or not its mask bit is set.
- R3: `irq` is a register holding the OR over the three bits of status AND mask. It follows a status or mask change one clock later.
- R4: A read (`reg_rd` high) of an acknowledge location returns zero in that cycle and clears the matching status bit on that clock edge.
- R5: When a set event and an acknowledge read of the same bit fall in the same cycle, the bit ends up set.
- R6: With a line count N greater than zero, the cursor event fires on the N-th line-end strobe after arming and then on every N-th strobe after that. With N equal to zero it never fires.
- R7: A write to the cursor line count restarts the line counting only when mask bit 2 is set. Otherwise counting carries on from its current position, and a re-arming write in the same cycle as a line-end strobe suppresses that strobe.
- R8: The status and the cursor line count read back as held. Writes to the status and acknowledge locations change nothing.
- R9: After reset the mask, status, line count and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vblank_evt | input | 1 | One-cycle vertical blank event |
| anim_evt | input | 1 | One-cycle animation line event |
| line_end | input | 1 | One-cycle end-of-line strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe (drives the acknowledge side effect) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong status bit shows on the status read-back in the cycle after the edge that corrupted it. When its mask bit is set, it also shows on `irq` one edge later. A cursor line counter that is off by even one line moves the cursor status bit by a whole strobe interval, so the error appears at the first expected firing. The bench drives the status address whenever it is idle, which lets the reference model compare status and `irq` on every clock. Any divergence is therefore reported within two cycles of its cause.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
   localparam int unsigned NSRC      = 3;
   localparam int unsigned SRC_VBL   = 0;
   localparam int unsigned SRC_ANIM  = 1;
   localparam int unsigned SRC_CUR   = 2;

   localparam int unsigned A_MASK    = 0;
   localparam int unsigned A_STATUS  = 1;
   localparam int unsigned A_CLINE   = 2;
   localparam int unsigned A_ACK_CUR = 3;
   localparam int unsigned A_ACK_ANI = 4;
   localparam int unsigned A_ACK_VBL = 5;
endpackage

// File: rtl/rirq_line_timer.sv
module rirq_line_timer #(
   parameter int unsigned LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_end,
   input  logic [LINE_W-1:0] period,
   input  logic              rearm,
   output logic              fire
);
   localparam logic [LINE_W:0] ONE = (LINE_W+1)'(1);

   logic [LINE_W-1:0] cnt_q;
   logic              run;
   logic              last_line;

   assign run       = (period != '0);
   assign last_line = run && (({1'b0, cnt_q} + ONE) >= {1'b0, period});
   assign fire      = line_end && !rearm && last_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (rearm)            cnt_q <= '0;
      else if (line_end && run)  cnt_q <= last_line ? '0 : cnt_q + 1'b1;
   end

   // R6: a zero line count never produces a cursor event
   a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0) |-> !fire);
   // R6: counting restarts after every firing
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt_q == '0));
   // R7: a re-arming write restarts the count
   a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> (cnt_q == '0));
endmodule

// File: rtl/rirq_status_bank.sv
module rirq_status_bank #(
   parameter int unsigned NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic [NSRC-1:0] clr,
   input  logic            mask_wr,
   input  logic [NSRC-1:0] mask_wdata,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] mask,
   output logic            irq
);
   logic [NSRC-1:0] mask_q;
   logic            irq_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st_q <= 1'b0;
         else if (set[i]) st_q <= 1'b1;
         else if (clr[i]) st_q <= 1'b0;
      end
      assign status[i] = st_q;

      // R5: a set in the same cycle as a clear wins
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> status[i]);
      // R4: a lone acknowledge clears the bit
      a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !status[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status & mask_q);
   end

   assign mask = mask_q;
   assign irq  = irq_q;

   // R3: with no enabled bit across two cycles the line stays low
   a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_q == '0) && $past(mask_q == '0)) |-> !irq_q);
   // R1: mask write takes the written value
   a_r1_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(mask_wdata)));
endmodule

// File: rtl/rirq_regif.sv
module rirq_regif
   import rirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [NSRC-1:0]   status,
   input  logic [NSRC-1:0]   mask,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NSRC-1:0]   clr,
   output logic              mask_wr,
   output logic              rearm,
   output logic [LINE_W-1:0] cline
);
   logic [LINE_W-1:0] cline_q;
   logic              cline_wr;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:LINE_W];
   assign mask_wr  = reg_wr && (reg_addr == ADDR_W'(A_MASK));
   assign cline_wr = reg_wr && (reg_addr == ADDR_W'(A_CLINE));
   assign rearm    = cline_wr && mask[SRC_CUR];

   assign clr[SRC_CUR]  = reg_rd && (reg_addr == ADDR_W'(A_ACK_CUR));
   assign clr[SRC_ANIM] = reg_rd && (reg_addr == ADDR_W'(A_ACK_ANI));
   assign clr[SRC_VBL]  = reg_rd && (reg_addr == ADDR_W'(A_ACK_VBL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cline_q <= '0;
      else if (cline_wr) cline_q <= reg_wdata[LINE_W-1:0];
   end
   assign cline = cline_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_MASK))        reg_rdata = DATA_W'(mask);
      else if (reg_addr == ADDR_W'(A_STATUS)) reg_rdata = DATA_W'(status);
      else if (reg_addr == ADDR_W'(A_CLINE))  reg_rdata = DATA_W'(cline_q);
   end

   // R4: acknowledge locations always read as zero
   a_r4_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr) |-> (reg_rdata == '0));
   // R8: the line count holds when not written
   a_r8_cline_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cline_wr |=> $stable(cline_q));
endmodule

// File: rtl/rirq_ctrl.sv
module rirq_ctrl
   import rirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank_evt,
   input  logic              anim_evt,
   input  logic              line_end,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   if (ADDR_W < 3)       begin : g_bad_addr  $error("ADDR_W must be at least 3"); end
   if (LINE_W < 2)       begin : g_bad_line  $error("LINE_W must be at least 2"); end
   if (DATA_W <= LINE_W) begin : g_bad_data  $error("DATA_W must exceed LINE_W"); end

   logic [NSRC-1:0]   set;
   logic [NSRC-1:0]   clr;
   logic [NSRC-1:0]   status;
   logic [NSRC-1:0]   mask;
   logic              mask_wr;
   logic              rearm;
   logic              cur_fire;
   logic [LINE_W-1:0] cline;

   assign set[SRC_VBL]  = vblank_evt;
   assign set[SRC_ANIM] = anim_evt;
   assign set[SRC_CUR]  = cur_fire;

   rirq_line_timer #(.LINE_W(LINE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .line_end(line_end), .period(cline),
      .rearm(rearm), .fire(cur_fire));

   rirq_status_bank #(.NSRC(NSRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .set(set), .clr(clr), .mask_wr(mask_wr),
      .mask_wdata(reg_wdata[NSRC-1:0]), .status(status), .mask(mask), .irq(irq));

   rirq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_regif (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .status(status), .mask(mask),
      .reg_rdata(reg_rdata), .clr(clr), .mask_wr(mask_wr), .rearm(rearm),
      .cline(cline));

   // R2: vertical blank is recorded regardless of the mask
   a_r2_vbl_latch: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_evt |=> status[SRC_VBL]);
   // R6: cursor events only come on a line-end strobe
   a_r6_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cur_fire |-> line_end);
endmodule

// File: tb/rirq_ctrl_tb.sv
module rirq_ctrl_tb;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 16;
   localparam int LINE_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vblank_evt = 0, anim_evt = 0, line_end = 0;
   logic [ADDR_W-1:0] reg_addr = 1;
   logic              reg_rd = 0, reg_wr = 0;
   logic [DATA_W-1:0] reg_wdata = 0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq;

   always #10 clk = ~clk;

   rirq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .vblank_evt(vblank_evt), .anim_evt(anim_evt),
      .line_end(line_end), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   int n_chk = 0, n_fail = 0;
   string req = "R9";
   int m_status = 0, m_mask = 0, m_cline = 0, m_cnt = 0, m_irq = 0;
   bit done = 0;

   function automatic int model_rd(int a);
      case (a)
         0: return m_mask;
         1: return m_status;
         2: return m_cline;
         default: return 0;
      endcase
   endfunction

   task automatic check(string r, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   task automatic model_edge(bit v, bit a, bit le, bit rd, bit wr, int ad, int wd);
      int clr, set, fire, st;
      fire = 0;
      if (wr && ad == 2 && (m_mask & 4) != 0) m_cnt = 0;
      else if (le && m_cline != 0) begin
         if (m_cnt + 1 >= m_cline) begin fire = 1; m_cnt = 0; end
         else m_cnt++;
      end
      clr = 0;
      if (rd && ad == 3) clr |= 4;
      if (rd && ad == 4) clr |= 2;
      if (rd && ad == 5) clr |= 1;
      set = (v ? 1 : 0) | (a ? 2 : 0) | (fire ? 4 : 0);
      m_irq = ((m_status & m_mask) != 0) ? 1 : 0;
      st = (m_status & ~clr) | set;
      m_status = st & 7;
      if (wr && ad == 0) m_mask = wd & 7;
      if (wr && ad == 2) m_cline = wd & ((1 << LINE_W) - 1);
   endtask

   task automatic cyc(bit v, bit a, bit le, bit rd, bit wr, int ad, int wd);
      vblank_evt = v; anim_evt = a; line_end = le;
      reg_rd = rd; reg_wr = wr; reg_addr = ADDR_W'(ad); reg_wdata = DATA_W'(wd);
      #1;
      check(req, $sformatf("rdata@%0d", ad), int'(reg_rdata), model_rd(ad));
      @(posedge clk);
      model_edge(v, a, le, rd, wr, ad, wd);
      @(negedge clk);
      check(req, "irq", int'(irq), m_irq);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, 0);
   endtask

   task automatic lines(int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, 0, 1, 0, 0, 1, 0);
         cyc(0, 0, 0, 0, 0, 1, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset values
      req = "R9";
      for (int a = 0; a < 8; a++) cyc(0, 0, 0, 0, 0, a, 0);
      // R2: unmasked events still latch
      req = "R2";
      cyc(1, 0, 0, 0, 0, 1, 0); cyc(0, 1, 0, 0, 0, 1, 0); idle(2);
      // R3: mask enables the line one cycle later
      req = "R3";
      cyc(0, 0, 0, 0, 1, 0, 1); idle(2);
      cyc(0, 0, 0, 0, 1, 0, 2); idle(2);
      // R4: acknowledge reads zero and clears
      req = "R4";
      cyc(0, 0, 0, 1, 0, 5, 0); cyc(0, 0, 0, 1, 0, 4, 0); idle(2);
      // R5: set beats clear in the same cycle
      req = "R5";
      cyc(0, 1, 0, 1, 0, 4, 0); idle(2);
      cyc(1, 0, 0, 1, 0, 5, 0); idle(1);
      // R8: status and acknowledge writes have no effect
      req = "R8";
      cyc(0, 0, 0, 0, 1, 1, 0); cyc(0, 0, 0, 0, 1, 3, 16'hFFFF); idle(1);
      cyc(0, 0, 0, 0, 0, 2, 0);
      cyc(0, 0, 0, 1, 0, 4, 0); cyc(0, 0, 0, 1, 0, 5, 0); idle(1);
      // R6: cursor event every N lines
      req = "R6";
      cyc(0, 0, 0, 0, 1, 0, 4); cyc(0, 0, 0, 0, 1, 2, 3); idle(1);
      lines(7);
      cyc(0, 0, 0, 1, 0, 3, 0); idle(1);
      lines(2);
      // R7: write without cursor mask keeps counting; with mask restarts
      req = "R7";
      cyc(0, 0, 0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 1, 2, 4); lines(2);
      cyc(0, 0, 0, 1, 0, 3, 0);
      cyc(0, 0, 0, 0, 1, 0, 4); lines(1);
      cyc(0, 0, 1, 0, 1, 2, 2); lines(1); idle(1); lines(1);
      cyc(0, 0, 0, 1, 0, 3, 0); lines(3);
      // R6: zero count disables
      req = "R6";
      cyc(0, 0, 0, 1, 0, 3, 0); cyc(0, 0, 0, 0, 1, 2, 0); lines(6);
      // R1: mixed traffic across the address map
      req = "R1";
      for (int i = 0; i < 600; i++) begin
         int ad = $urandom_range(0, 7);
         int wd = (ad == 2) ? $urandom_range(0, 5) : $urandom_range(0, 255);
         cyc($urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
             $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
             $urandom_range(0, 5) == 0, ad, wd);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule